// File: doc/BRIEF.md
# Dual-Queue Programmable Flag Router

This block derives the status flags of a bidirectional FIFO made of two one-way queues, one carrying data from side A to side B and one from side B to side A. The queue memories live elsewhere. Each queue reports its occupancy to this block as a count of stored words. From that count the block derives four flags per queue: empty, almost-empty, full and almost-full. Two of the four per-queue flags use programmable thresholds.

A small configuration port writes eight 16-bit registers, selected by a 3-bit index.
- Registers 0 to 3 hold the four almost-thresholds.
- Register 4 maps any of the eight internal flags onto each of four external flag pins.
- Bit 11 of register 7 lets an externally computed parity-error signal take over the first pin.

All eight internal flags are also presented at once on a status vector. A software clear input returns the thresholds to zero without a full reset.

Top module: `dual_queue_flag_router`

## Requirements
- R1: While `rst` is high, and on the first edge where it is sampled high, the following reset values apply. `status_flags` becomes 8'h33, meaning both empty and both almost-empty flags are set and both full flags are clear. `flag_pins` becomes 0. All thresholds, the pin map and the parity override become zero.
- R2: An empty flag is set exactly when its queue's occupancy is 0, and a full flag exactly when the occupancy equals `DEPTH`. Both reflect the occupancy sampled one clock edge earlier.
- R3: An almost-empty flag is set when the occupancy is at or below its threshold. It reflects the occupancy and threshold sampled two clock edges earlier. It therefore never changes on the same edge as empty when both respond to the same occupancy change, even with a zero threshold.
- R4: An almost-full flag is set when the free space (`DEPTH` minus occupancy) is at or below its threshold. Like almost-empty, it lags by two edges.
- R5: Register indices 0, 1, 2 and 3 hold, in bits 9:0, the A-to-B almost-empty, A-to-B almost-full, B-to-A almost-empty and B-to-A almost-full thresholds. Bits 15:10 of those registers are ignored.
- R6: A cycle with `soft_clr` high sets all four thresholds to zero on the next edge, overriding a threshold write in the same cycle. It leaves the pin map and parity override unchanged.
- R7: Register 4 holds one 4-bit code per pin: bits 3:0 for pin 0, bits 7:4 for pin 1, bits 11:8 for pin 2 and bits 15:12 for pin 3. Code bits 1:0 pick the kind of flag: 00 empty, 01 almost-empty, 10 full, 11 almost-full. Code bit 2 picks the queue: 0 for A-to-B, 1 for B-to-A. Each pin shows its selected status bit one edge after the status bit, the map and the override.
- R8: Code bit 3 is ignored, so codes 8 to 15 route the same flags as codes 0 to 7.
- R9: When bit 11 of register 7 is set, `flag_pins[0]` carries `par_err` delayed by one edge and pin 0's code is ignored. The other bits of register 7 have no effect.
- R10: `status_flags` bit 4q+k holds flag kind k of queue q, where q is 0 for A-to-B and 1 for B-to-A. Kind k is 0 for empty, 1 for almost-empty, 2 for full and 3 for almost-full, so a pin code's low three bits equal the status bit index it routes.
- R11: Writes to register indices 5 and 6 are accepted and have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Clears all four thresholds |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write data |
| ab_level | input | CNT_W | A-to-B queue occupancy in words (0..DEPTH) |
| ba_level | input | CNT_W | B-to-A queue occupancy in words (0..DEPTH) |
| par_err | input | 1 | Parity error from the datapath |
| flag_pins | output | 4 | Routed external flags, registered, active high |
| status_flags | output | 8 | All eight internal flags |

## Verification
Several conditions are hard to reach from the ports.

The first is the one-edge separation between empty and almost-empty, and between full and almost-full, with a zero threshold. It only shows when the occupancy crosses 0 or `DEPTH` one word at a time. The stimulus therefore ramps each queue through both ends word by word, both with zero thresholds and with small non-zero ones, and also jumps straight between the extremes.

The second is the code aliasing and pin-0 override. The stimulus steps through all sixteen codes on all four pins at once, with occupancies that make every flag both set and clear. It then toggles `par_err` with the override on and off.

// File: rtl/frt_pkg.sv
package frt_pkg;

    localparam int OFS_W       = 10;
    localparam int REG_W       = 16;
    localparam int ADDR_W      = 3;
    localparam int CODE_W      = 4;
    localparam int SEL_W       = 3;
    localparam int NUM_PINS    = 4;
    localparam int NUM_Q       = 2;
    localparam int FLAGS_PER_Q = 4;
    localparam int NUM_FLAGS   = NUM_Q * FLAGS_PER_Q;
    localparam int NUM_OFS     = NUM_Q * 2;
    localparam int PAR_OVR_BIT = 11;

    typedef enum logic [ADDR_W-1:0] {
        CFG_AB_AE  = 3'd0,
        CFG_AB_AF  = 3'd1,
        CFG_BA_AE  = 3'd2,
        CFG_BA_AF  = 3'd3,
        CFG_PINMAP = 3'd4,
        CFG_GEN    = 3'd5,
        CFG_RSVD   = 3'd6,
        CFG_PARITY = 3'd7
    } cfg_addr_e;

    // Packed so that bit k of the struct is flag kind k.
    typedef struct packed {
        logic afull;
        logic full;
        logic aempty;
        logic empty;
    } qflags_t;

    typedef struct packed {
        logic [OFS_W-1:0] af;
        logic [OFS_W-1:0] ae;
    } thresh_t;

    localparam qflags_t QFLAGS_RST = '{afull: 1'b0, full: 1'b0, aempty: 1'b1, empty: 1'b1};

    function automatic logic route_flag(input logic [NUM_FLAGS-1:0] flags,
                                        input logic [SEL_W-1:0]     sel);
        return flags[sel];
    endfunction

    function automatic logic at_or_below(input int unsigned value,
                                         input int unsigned limit);
        return value <= limit;
    endfunction

endpackage

// File: rtl/frt_cfg_regs.sv
module frt_cfg_regs
    import frt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_clr,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output thresh_t           thr_ab,
    output thresh_t           thr_ba,
    output logic [REG_W-1:0]  pin_map,
    output logic              par_ovr
);

    logic [OFS_W-1:0] ofs_q [NUM_OFS];

    // Threshold registers: index i of the register file is threshold i.
    for (genvar i = 0; i < NUM_OFS; i++) begin : g_ofs
        always_ff @(posedge clk) begin
            if (rst || soft_clr) begin
                ofs_q[i] <= '0;
            end else if (we && addr == ADDR_W'(i)) begin
                ofs_q[i] <= wdata[OFS_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_map <= '0;
        end else if (we && addr == CFG_PINMAP) begin
            pin_map <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            par_ovr <= 1'b0;
        end else if (we && addr == CFG_PARITY) begin
            par_ovr <= wdata[PAR_OVR_BIT];
        end
    end

    // Indices 5 and 6 are decoded nowhere: such writes land on no storage.
    assign thr_ab = '{af: ofs_q[int'(CFG_AB_AF)], ae: ofs_q[int'(CFG_AB_AE)]};
    assign thr_ba = '{af: ofs_q[int'(CFG_BA_AF)], ae: ofs_q[int'(CFG_BA_AE)]};

endmodule

// File: rtl/frt_queue_flags.sv
module frt_queue_flags
    import frt_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] level,
    input  thresh_t          thr,
    output qflags_t          flags
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic             empty_q, full_q;
    logic             ae_s1, af_s1;
    logic             ae_q, af_q;
    logic [CNT_W-1:0] free_words;

    assign free_words = FULL_CNT - level;

    // Stage 1: hard flags final here, almost flags captured raw.
    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= QFLAGS_RST.empty;
            full_q  <= QFLAGS_RST.full;
            ae_s1   <= QFLAGS_RST.aempty;
            af_s1   <= QFLAGS_RST.afull;
        end else begin
            empty_q <= (level == '0);
            full_q  <= (level == FULL_CNT);
            ae_s1   <= at_or_below(32'(level), 32'(thr.ae));
            af_s1   <= at_or_below(32'(free_words), 32'(thr.af));
        end
    end

    // Stage 2: almost flags retimed one edge behind empty and full.
    always_ff @(posedge clk) begin
        if (rst) begin
            ae_q <= QFLAGS_RST.aempty;
            af_q <= QFLAGS_RST.afull;
        end else begin
            ae_q <= ae_s1;
            af_q <= af_s1;
        end
    end

    assign flags = '{afull: af_q, full: full_q, aempty: ae_q, empty: empty_q};

endmodule

// File: rtl/frt_pin_mux.sv
module frt_pin_mux
    import frt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [REG_W-1:0]     pin_map,
    input  logic                 par_ovr,
    input  logic                 par_err,
    output logic [NUM_PINS-1:0]  pins
);

    logic [NUM_PINS-1:0] pin_nxt;
    logic                unused_alias_bits;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic routed;
        assign routed = route_flag(flags, pin_map[p*CODE_W +: SEL_W]);
        if (p == 0) begin : g_ovr
            assign pin_nxt[p] = par_ovr ? par_err : routed;
        end else begin : g_plain
            assign pin_nxt[p] = routed;
        end
    end

    // The top bit of each code is an alias bit and selects nothing.
    assign unused_alias_bits = ^{pin_map[15], pin_map[11], pin_map[7], pin_map[3]};

    always_ff @(posedge clk) begin
        if (rst) begin
            pins <= '0;
        end else begin
            pins <= pin_nxt;
        end
    end

endmodule

// File: rtl/dual_queue_flag_router.sv
module dual_queue_flag_router
    import frt_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 soft_clr,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [REG_W-1:0]     cfg_wdata,
    input  logic [CNT_W-1:0]     ab_level,
    input  logic [CNT_W-1:0]     ba_level,
    input  logic                 par_err,
    output logic [NUM_PINS-1:0]  flag_pins,
    output logic [NUM_FLAGS-1:0] status_flags
);

    thresh_t          thr_ab, thr_ba;
    logic [REG_W-1:0] pin_map;
    logic             par_ovr;

    thresh_t          thr_arr [NUM_Q];
    logic [CNT_W-1:0] lvl_arr [NUM_Q];
    qflags_t          qf_arr  [NUM_Q];

    frt_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .soft_clr (soft_clr),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .thr_ab   (thr_ab),
        .thr_ba   (thr_ba),
        .pin_map  (pin_map),
        .par_ovr  (par_ovr)
    );

    assign thr_arr[0] = thr_ab;
    assign thr_arr[1] = thr_ba;
    assign lvl_arr[0] = ab_level;
    assign lvl_arr[1] = ba_level;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        frt_queue_flags #(.DEPTH(DEPTH)) u_flags (
            .clk   (clk),
            .rst   (rst),
            .level (lvl_arr[q]),
            .thr   (thr_arr[q]),
            .flags (qf_arr[q])
        );
        assign status_flags[q*FLAGS_PER_Q +: FLAGS_PER_Q] = qf_arr[q];
    end

    frt_pin_mux u_mux (
        .clk     (clk),
        .rst     (rst),
        .flags   (status_flags),
        .pin_map (pin_map),
        .par_ovr (par_ovr),
        .par_err (par_err),
        .pins    (flag_pins)
    );

endmodule

// File: rtl/frt_checker.sv
module frt_checker
    import frt_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 soft_clr,
    input logic [CNT_W-1:0]     ab_level,
    input logic [CNT_W-1:0]     ba_level,
    input logic                 par_err,
    input logic [NUM_PINS-1:0]  flag_pins,
    input logic [NUM_FLAGS-1:0] status_flags,
    input thresh_t              thr_ab,
    input thresh_t              thr_ba,
    input logic [REG_W-1:0]     pin_map,
    input logic                 par_ovr
);

    logic [1:0]          warm;
    logic [NUM_PINS-1:0] exp_pins;

    // Counts edges since reset so no property reaches back past it.
    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= 2'd0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            exp_pins[p] = status_flags[pin_map[p*CODE_W +: SEL_W]];
        end
        if (par_ovr) exp_pins[0] = par_err;
    end

    assert_ab_empty_lag_R2: assert property (@(posedge clk) disable iff (rst || warm == 2'd0)
        status_flags[0] == ($past(ab_level) == '0));

    assert_ba_full_lag_R2: assert property (@(posedge clk) disable iff (rst || warm == 2'd0)
        status_flags[6] == ($past(ba_level) == CNT_W'(DEPTH)));

    assert_ab_aempty_lag_R3: assert property (@(posedge clk) disable iff (rst || warm < 2'd2)
        status_flags[1] == $past(32'(ab_level) <= 32'(thr_ab.ae), 2));

    assert_ba_afull_lag_R4: assert property (@(posedge clk) disable iff (rst || warm < 2'd2)
        status_flags[7] == $past((32'(DEPTH) - 32'(ba_level)) <= 32'(thr_ba.af), 2));

    assert_soft_clear_R6: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (thr_ab == '0 && thr_ba == '0));

    assert_pin_route_R7: assert property (@(posedge clk) disable iff (rst || warm == 2'd0)
        flag_pins == $past(exp_pins));

    assert_parity_pin_R9: assert property (@(posedge clk) disable iff (rst)
        par_ovr |=> flag_pins[0] == $past(par_err));

endmodule

bind dual_queue_flag_router frt_checker #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .soft_clr     (soft_clr),
    .ab_level     (ab_level),
    .ba_level     (ba_level),
    .par_err      (par_err),
    .flag_pins    (flag_pins),
    .status_flags (status_flags),
    .thr_ab       (thr_ab),
    .thr_ba       (thr_ba),
    .pin_map      (pin_map),
    .par_ovr      (par_ovr)
);

// File: tb/dual_queue_flag_router_tb.sv
module dual_queue_flag_router_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;
    localparam int CNT_W      = $clog2(DEPTH + 1);

    typedef struct {
        logic [7:0] st;
        logic [3:0] pins;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             soft_clr = 1'b0;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_addr = '0;
    logic [15:0]      cfg_wdata = '0;
    logic [CNT_W-1:0] ab_level = '0;
    logic [CNT_W-1:0] ba_level = '0;
    logic             par_err = 1'b0;
    logic [3:0]       flag_pins;
    logic [7:0]       status_flags;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string phase = "R1 reset";
    exp_t  exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_queue_flag_router #(.DEPTH(DEPTH)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .soft_clr     (soft_clr),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .ab_level     (ab_level),
        .ba_level     (ba_level),
        .par_err      (par_err),
        .flag_pins    (flag_pins),
        .status_flags (status_flags)
    );

    // Reference model built from the requirements; pushes one expected item per edge.
    int         m_ofs [4];
    logic [15:0] m_map;
    logic        m_par;
    logic [7:0]  m_stat;
    logic [3:0]  m_pins;
    logic [1:0]  m_ae1, m_af1;

    always @(posedge clk) begin
        exp_t item;
        if (rst) begin
            foreach (m_ofs[i]) m_ofs[i] = 0;
            m_map = '0; m_par = 1'b0;
            m_stat = 8'h33; m_pins = '0;
            m_ae1 = 2'b11; m_af1 = 2'b00;
        end else begin
            logic [3:0] np;
            logic [7:0] ns;
            for (int p = 0; p < 4; p++) begin
                np[p] = m_stat[m_map[p*4 +: 3]];           // R7 R8
            end
            if (m_par) np[0] = par_err;                    // R9
            for (int q = 0; q < 2; q++) begin
                int lv;
                lv = (q == 0) ? int'(ab_level) : int'(ba_level);
                ns[q*4 + 0] = (lv == 0);
                ns[q*4 + 2] = (lv == DEPTH);
                ns[q*4 + 1] = m_ae1[q];
                ns[q*4 + 3] = m_af1[q];
                m_ae1[q] = (lv <= m_ofs[q*2]);
                m_af1[q] = ((DEPTH - lv) <= m_ofs[q*2 + 1]);
            end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0, 3'd1, 3'd2, 3'd3: m_ofs[cfg_addr] = int'(cfg_wdata[9:0]);
                    3'd4: m_map = cfg_wdata;
                    3'd7: m_par = cfg_wdata[11];
                    default: ;                             // R11
                endcase
            end
            if (soft_clr) foreach (m_ofs[i]) m_ofs[i] = 0;  // R6
            m_stat = ns;
            m_pins = np;
        end
        item.st = m_stat;
        item.pins = m_pins;
        exp_q.push_back(item);
    end

    function automatic string st_tag(int b);
        case (b % 4)
            0, 2:    return "R2";
            1:       return "R3";
            default: return "R4";
        endcase
    endfunction

    // Monitor: pops expected items and compares away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0 && !done) begin
            exp_t e;
            e = exp_q.pop_front();
            for (int b = 0; b < 8; b++) begin
                checks++;
                if (status_flags[b] !== e.st[b]) begin
                    failures++;
                    $display("FAIL %s (%s) status bit %0d (R10 order): got %b expected %b",
                             st_tag(b), phase, b, status_flags[b], e.st[b]);
                end
            end
            for (int p = 0; p < 4; p++) begin
                checks++;
                if (flag_pins[p] !== e.pins[p]) begin
                    failures++;
                    $display("FAIL %s (%s) pin %0d: got %b expected %b",
                             (p == 0) ? "R7/R9" : "R7", phase, p, flag_pins[p], e.pins[p]);
                end
            end
        end
    end

    task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_lv(input int ab, input int ba);
        @(negedge clk);
        ab_level = CNT_W'(ab);
        ba_level = CNT_W'(ba);
    endtask

    task automatic rand_lv(input int n);
        for (int i = 0; i < n; i++) begin
            int pick;
            pick = int'($urandom_range(0, 3));
            case (pick)
                0:       set_lv(0, DEPTH);
                1:       set_lv(DEPTH, 0);
                default: set_lv(int'($urandom_range(0, DEPTH)), int'($urandom_range(0, DEPTH)));
            endcase
            par_err = 1'($urandom_range(0, 1));
        end
    endtask

    task automatic ramps(input int span);
        for (int i = span; i >= 0; i--) set_lv(i, DEPTH - i);
        for (int i = 0; i <= span; i++) set_lv(i, DEPTH - i);
        for (int i = span; i >= 0; i--) set_lv(DEPTH - i, i);
        for (int i = 0; i <= span; i++) set_lv(DEPTH - i, i);
        set_lv(0, 0); set_lv(DEPTH, DEPTH); set_lv(0, 0); set_lv(DEPTH, DEPTH);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (%s): got timeout expected completion", phase);
            finish_run();
        end
    end

    initial begin
        ab_level = CNT_W'(7); ba_level = CNT_W'(DEPTH);
        repeat (3) @(negedge clk);                 // R1 reset values checked by monitor
        rst = 1'b0;

        phase = "R2 R3 R10 zero thresholds";
        cfg_write(3'd4, 16'h6240);                 // pins: AB empty, BA empty, AB full, BA full
        ramps(4);
        cfg_write(3'd4, 16'h7531);                 // pins: all four almost flags
        ramps(4);

        phase = "R5 R4 thresholds upper bits ignored";
        cfg_write(3'd0, 16'hFC05);
        cfg_write(3'd1, 16'hA807);
        cfg_write(3'd2, 16'h0403);
        cfg_write(3'd3, 16'hFC02);
        ramps(12);
        cfg_write(3'd0, 16'h03FF);
        cfg_write(3'd3, 16'h0200);
        rand_lv(40);

        phase = "R6 soft clear";
        @(negedge clk);
        soft_clr = 1'b1; cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 16'h0011;
        @(negedge clk);
        soft_clr = 1'b0; cfg_we = 1'b0;
        ramps(4);

        phase = "R7 R8 every code on every pin";
        cfg_write(3'd0, 16'h0006);
        cfg_write(3'd3, 16'h0009);
        for (int c = 0; c < 16; c++) begin
            cfg_write(3'd4, {4{4'(c)}});
            set_lv(0, DEPTH); set_lv(0, DEPTH); set_lv(3, 5); set_lv(DEPTH, 0);
            set_lv(DEPTH, 0); set_lv(DEPTH - 3, 2); set_lv(500, 700);
            rand_lv(4);
        end
        for (int k = 0; k < 20; k++) begin
            cfg_write(3'd4, 16'($urandom));
            rand_lv(6);
        end

        phase = "R9 parity override";
        cfg_write(3'd4, 16'h5555);
        cfg_write(3'd7, 16'h0800);
        rand_lv(30);
        cfg_write(3'd7, 16'hF7FF);                 // bit 11 clear, others set: override off
        rand_lv(20);
        cfg_write(3'd7, 16'hFFFF);
        rand_lv(20);
        cfg_write(3'd7, 16'h0000);
        rand_lv(10);

        phase = "R11 ignored registers";
        cfg_write(3'd4, 16'hB3E1);
        set_lv(0, DEPTH); set_lv(0, DEPTH);
        cfg_write(3'd5, 16'hFFFF);
        cfg_write(3'd6, 16'hFFFF);
        repeat (4) @(negedge clk);
        set_lv(DEPTH, 5);
        cfg_write(3'd5, 16'h0000);
        cfg_write(3'd6, 16'h1234);
        repeat (4) @(negedge clk);

        phase = "R2 R3 R4 R7 mixed";
        for (int k = 0; k < 200; k++) begin
            if (($urandom % 8) == 0) cfg_write(3'($urandom_range(0, 7)), 16'($urandom_range(0, 65535)));
            if (($urandom % 64) == 0) begin
                @(negedge clk); soft_clr = 1'b1;
                @(negedge clk); soft_clr = 1'b0;
            end
            rand_lv(2);
        end

        phase = "R1 reset again";
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule